// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block drives an active-low system reset from three sources. The first is a digital supply comparator, which has a falling "supply failed" flag and a separate rising "supply recovered above the hysteresis level" flag. The second is an active-low manual reset button. The third is a watchdog that signals a fault with a single-cycle pulse. While any source is active, the reset output stays low. Once every source has let go, the output stays low for a further timeout whose length, in clock cycles, comes from an input port. The output then goes high.

The supply input passes through a dip filter, so brief sags never start a reset. The manual input passes through a symmetric debounce filter. This filter rejects short presses and short releases and adds a small fixed delay to a valid press. A watchdog pulse lasts only one cycle, yet it produces a reset of the full timeout length. A two-bit cause code reports which source caused the most recent reset.

Top module: `supv_reset_seq`

## Requirements
- R1: While `arst_n` is low, `sys_rst_n_o` is 0 and `cause_o` is 0 (power-on). After `arst_n` rises, the first clock edge loads the timeout, and `sys_rst_n_o` goes high at edge LEN+1, where LEN is `rst_len_i`.
- R2: A supply fault is declared only after `supply_fail_i` has been sampled high on DIP_FILT consecutive edges. A dip of DIP_FILT-1 cycles never pulls the output low. A declared fault pulls `sys_rst_n_o` low one edge later.
- R3: A declared supply fault stays in force, even after `supply_fail_i` returns low, until an edge samples `supply_ok_rise_i`=1 with `supply_fail_i`=0.
- R4: Manual reset becomes active only after `mr_n_i` has been sampled low on MR_MIN consecutive edges, and it pulls the output low one edge later. A press of MR_MIN-1 cycles has no effect.
- R5: Manual reset becomes inactive only after `mr_n_i` has been sampled high on MR_MIN consecutive edges. A shorter release leaves the output low.
- R6: Each edge that samples `wdog_fault_i`=1 pulls `sys_rst_n_o` low at that edge. A single-cycle pulse keeps the output low until the LEN-th following edge.
- R7: Any active source during the countdown reloads it. The output goes high at the LEN-th edge after the first edge that samples no source active.
- R8: `cause_o` encodes 1 = supply, 2 = manual, 3 = watchdog and 0 = power-on. It is updated on every edge at which a source is active, with priority supply over manual over watchdog.
- R9: `rst_len_i` is sampled each time the countdown loads. A value of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous block reset, active low |
| supply_fail_i | input | 1 | Supply below falling threshold |
| supply_ok_rise_i | input | 1 | Supply above threshold plus hysteresis |
| mr_n_i | input | 1 | Manual reset, active low |
| wdog_fault_i | input | 1 | Watchdog fault pulse |
| rst_len_i | input | CNT_W | Reset timeout in clock cycles |
| sys_rst_n_o | output | 1 | System reset, active low |
| cause_o | output | 2 | Cause of the most recent reset |

## Verification
Two events can coincide on a single edge. The first case is a watchdog pulse that lands on the exact edge at which the countdown would otherwise release. The bench places the pulse there and expects the output to stay low for another full LEN cycles, not to flicker high. The second case is a supply fault and a manual press that are active on the same edges. The bench holds both inputs together and judges the result by `cause_o`, which must report supply, and then manual once the supply recovers.

// File: rtl/supv_rst_pkg.sv
package supv_rst_pkg;
   typedef enum logic [1:0] {
      CAUSE_POR    = 2'd0,
      CAUSE_SUPPLY = 2'd1,
      CAUSE_MANUAL = 2'd2,
      CAUSE_WDOG   = 2'd3
   } rst_cause_e;

   // priority: supply, then manual, then watchdog
   function automatic rst_cause_e pick_cause(input logic sup, input logic man);
      if (sup)      return CAUSE_SUPPLY;
      else if (man) return CAUSE_MANUAL;
      else          return CAUSE_WDOG;
   endfunction
endpackage

// File: rtl/supv_dip_filter.sv
module supv_dip_filter #(
   parameter int FILT = 8
) (
   input  logic clk,
   input  logic arst_n,
   input  logic fail_i,
   input  logic ok_rise_i,
   output logic fault_o
);
   logic flt_q;

   generate
      if (FILT <= 1) begin : g_direct
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n)                       flt_q <= 1'b0;
            else if (!flt_q && fail_i)         flt_q <= 1'b1;
            else if (flt_q && ok_rise_i && !fail_i) flt_q <= 1'b0;
         end
      end else begin : g_count
         localparam int W = $clog2(FILT);
         logic [W-1:0] run_q;
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
               flt_q <= 1'b0;
               run_q <= '0;
            end else if (flt_q) begin
               run_q <= '0;
               if (ok_rise_i && !fail_i) flt_q <= 1'b0;
            end else if (fail_i) begin
               if (run_q == W'(FILT - 1)) begin
                  flt_q <= 1'b1;
                  run_q <= '0;
               end else begin
                  run_q <= run_q + 1'b1;
               end
            end else begin
               run_q <= '0;
            end
         end
      end
   endgenerate

   assign fault_o = flt_q;
endmodule

// File: rtl/supv_mr_filter.sv
module supv_mr_filter #(
   parameter int MIN = 4
) (
   input  logic clk,
   input  logic arst_n,
   input  logic mr_n_i,
   output logic active_o
);
   logic act_q;
   logic differ;

   assign differ = (~mr_n_i) != act_q;

   generate
      if (MIN <= 1) begin : g_direct
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) act_q <= 1'b0;
            else         act_q <= ~mr_n_i;
         end
      end else begin : g_count
         localparam int W = $clog2(MIN);
         logic [W-1:0] run_q;
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
               act_q <= 1'b0;
               run_q <= '0;
            end else if (differ) begin
               if (run_q == W'(MIN - 1)) begin
                  act_q <= ~act_q;
                  run_q <= '0;
               end else begin
                  run_q <= run_q + 1'b1;
               end
            end else begin
               run_q <= '0;
            end
         end
      end
   endgenerate

   assign active_o = act_q;
endmodule

// File: rtl/supv_hold_timer.sv
module supv_hold_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             hold_req_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             rst_n_o
);
   logic [CNT_W-1:0] left_q;
   logic             rst_n_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         left_q  <= '0;
         rst_n_q <= 1'b0;
      end else if (hold_req_i) begin
         left_q  <= len_i;
         rst_n_q <= 1'b0;
      end else if (left_q > CNT_W'(1)) begin
         left_q  <= left_q - 1'b1;
      end else begin
         left_q  <= '0;
         rst_n_q <= 1'b1;
      end
   end

   assign rst_n_o = rst_n_q;
endmodule

// File: rtl/supv_reset_seq.sv
module supv_reset_seq
   import supv_rst_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int DIP_FILT = 8,
   parameter int MR_MIN   = 4
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             supply_fail_i,
   input  logic             supply_ok_rise_i,
   input  logic             mr_n_i,
   input  logic             wdog_fault_i,
   input  logic [CNT_W-1:0] rst_len_i,
   output logic             sys_rst_n_o,
   output logic [1:0]       cause_o
);
   generate
      if (CNT_W < 2)    begin : g_bad_w   $error("CNT_W must be at least 2"); end
      if (DIP_FILT < 1) begin : g_bad_dip $error("DIP_FILT must be at least 1"); end
      if (MR_MIN < 1)   begin : g_bad_mr  $error("MR_MIN must be at least 1"); end
   endgenerate

   logic       sup_flt;
   logic       mr_act;
   logic       por_q;
   logic       src_any;
   logic       hold_req;
   rst_cause_e cause_q;

   supv_dip_filter #(.FILT(DIP_FILT)) u_dip (
      .clk(clk), .arst_n(arst_n),
      .fail_i(supply_fail_i), .ok_rise_i(supply_ok_rise_i),
      .fault_o(sup_flt)
   );

   supv_mr_filter #(.MIN(MR_MIN)) u_mr (
      .clk(clk), .arst_n(arst_n),
      .mr_n_i(mr_n_i), .active_o(mr_act)
   );

   assign src_any  = sup_flt | mr_act | wdog_fault_i;
   assign hold_req = src_any | por_q;

   supv_hold_timer #(.CNT_W(CNT_W)) u_hold (
      .clk(clk), .arst_n(arst_n),
      .hold_req_i(hold_req), .len_i(rst_len_i),
      .rst_n_o(sys_rst_n_o)
   );

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         por_q   <= 1'b1;
         cause_q <= CAUSE_POR;
      end else begin
         por_q <= 1'b0;
         if (src_any) cause_q <= pick_cause(sup_flt, mr_act);
      end
   end

   assign cause_o = cause_q;
endmodule

// File: rtl/supv_reset_seq_chk.sv
module supv_reset_seq_chk (
   input logic       clk,
   input logic       arst_n,
   input logic       wdog_fault_i,
   input logic       supply_ok_rise_i,
   input logic       sup_flt,
   input logic       mr_act,
   input logic       sys_rst_n_o,
   input logic [1:0] cause_o
);
   a_r6_wdog_pulls_low: assert property (@(posedge clk) disable iff (!arst_n)
      wdog_fault_i |=> !sys_rst_n_o);

   a_r4_manual_holds_low: assert property (@(posedge clk) disable iff (!arst_n)
      mr_act |=> !sys_rst_n_o);

   a_r2_supply_holds_low: assert property (@(posedge clk) disable iff (!arst_n)
      sup_flt |=> !sys_rst_n_o);

   a_r3_fault_latched: assert property (@(posedge clk) disable iff (!arst_n)
      (sup_flt && !supply_ok_rise_i) |=> sup_flt);

   a_r8_supply_first: assert property (@(posedge clk) disable iff (!arst_n)
      sup_flt |=> (cause_o == 2'd1));

   a_r8_wdog_alone: assert property (@(posedge clk) disable iff (!arst_n)
      (wdog_fault_i && !sup_flt && !mr_act) |=> (cause_o == 2'd3));

   a_r7_release_quiet: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(sys_rst_n_o) |-> (!$past(wdog_fault_i) && !$past(mr_act) && !$past(sup_flt)));
endmodule

bind supv_reset_seq supv_reset_seq_chk u_chk (
   .clk(clk), .arst_n(arst_n), .wdog_fault_i(wdog_fault_i),
   .supply_ok_rise_i(supply_ok_rise_i), .sup_flt(sup_flt), .mr_act(mr_act),
   .sys_rst_n_o(sys_rst_n_o), .cause_o(cause_o)
);

// File: tb/supv_reset_seq_test.sv
module supv_reset_seq_test;
   localparam int CNT_W = 16;
   localparam int D     = 8;
   localparam int M     = 4;
   localparam int LEN   = 20;

   logic             clk = 1'b0;
   logic             arst_n;
   logic             supply_fail_i, supply_ok_rise_i, mr_n_i, wdog_fault_i;
   logic [CNT_W-1:0] rst_len_i;
   logic             sys_rst_n_o;
   logic [1:0]       cause_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   supv_reset_seq #(.CNT_W(CNT_W), .DIP_FILT(D), .MR_MIN(M)) uut (
      .clk(clk), .arst_n(arst_n), .supply_fail_i(supply_fail_i),
      .supply_ok_rise_i(supply_ok_rise_i), .mr_n_i(mr_n_i),
      .wdog_fault_i(wdog_fault_i), .rst_len_i(rst_len_i),
      .sys_rst_n_o(sys_rst_n_o), .cause_o(cause_o)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic t_power_on();
      arst_n = 1'b0;
      tick(3);
      chk("R1 reset held in block reset", sys_rst_n_o, 0);
      chk("R1 cause power-on", cause_o, 0);
      arst_n = 1'b1;
      tick(LEN);
      chk("R1 still low at edge LEN", sys_rst_n_o, 0);
      tick(1);
      chk("R1 released at edge LEN+1", sys_rst_n_o, 1);
      chk("R1 cause stays power-on", cause_o, 0);
   endtask

   task automatic t_wdog();
      wdog_fault_i = 1'b1; tick(1); wdog_fault_i = 1'b0;
      chk("R6 low at fault edge", sys_rst_n_o, 0);
      chk("R8 cause watchdog", cause_o, 3);
      tick(LEN - 1);
      chk("R6 still low before LEN", sys_rst_n_o, 0);
      tick(1);
      chk("R6 high at LEN-th edge", sys_rst_n_o, 1);
   endtask

   task automatic t_len_zero();
      rst_len_i = '0;
      wdog_fault_i = 1'b1; tick(1); wdog_fault_i = 1'b0;
      chk("R9 zero length still asserts", sys_rst_n_o, 0);
      tick(1);
      chk("R9 zero length acts as one", sys_rst_n_o, 1);
      rst_len_i = CNT_W'(LEN);
   endtask

   task automatic t_reload();
      wdog_fault_i = 1'b1; tick(1); wdog_fault_i = 1'b0;
      tick(LEN - 1);
      chk("R7 low just before release", sys_rst_n_o, 0);
      wdog_fault_i = 1'b1; tick(1); wdog_fault_i = 1'b0;
      chk("R7 fault on release edge reloads", sys_rst_n_o, 0);
      tick(LEN - 1);
      chk("R7 reloaded count still running", sys_rst_n_o, 0);
      tick(1);
      chk("R7 released after full reload", sys_rst_n_o, 1);
   endtask

   task automatic t_short_dip();
      int low_seen = 0;
      supply_fail_i = 1'b1;
      for (int i = 0; i < D - 1; i++) begin
         tick(1);
         if (!sys_rst_n_o) low_seen++;
      end
      supply_fail_i = 1'b0;
      for (int i = 0; i < 4; i++) begin
         tick(1);
         if (!sys_rst_n_o) low_seen++;
      end
      chk("R2 short dip ignored (low cycles)", low_seen, 0);
   endtask

   task automatic t_supply();
      supply_fail_i = 1'b1;
      tick(D);
      chk("R2 output high at filter edge", sys_rst_n_o, 1);
      tick(1);
      chk("R2 low one edge after fault", sys_rst_n_o, 0);
      chk("R8 cause supply", cause_o, 1);
      supply_fail_i = 1'b0;
      tick(LEN + 5);
      chk("R3 fault held without recovery flag", sys_rst_n_o, 0);
      supply_ok_rise_i = 1'b1; tick(1); supply_ok_rise_i = 1'b0;
      tick(LEN - 1);
      chk("R3 countdown after recovery", sys_rst_n_o, 0);
      tick(1);
      chk("R3 released LEN edges after recovery", sys_rst_n_o, 1);
   endtask

   task automatic t_mr_short();
      int low_seen = 0;
      mr_n_i = 1'b0;
      for (int i = 0; i < M - 1; i++) begin
         tick(1);
         if (!sys_rst_n_o) low_seen++;
      end
      mr_n_i = 1'b1;
      for (int i = 0; i < 4; i++) begin
         tick(1);
         if (!sys_rst_n_o) low_seen++;
      end
      chk("R4 short press rejected (low cycles)", low_seen, 0);
   endtask

   task automatic t_mr();
      mr_n_i = 1'b0;
      tick(M);
      chk("R4 high at debounce edge", sys_rst_n_o, 1);
      tick(1);
      chk("R4 low after valid press", sys_rst_n_o, 0);
      chk("R8 cause manual", cause_o, 2);
      tick(3);
      mr_n_i = 1'b1; tick(M - 1); mr_n_i = 1'b0;
      tick(LEN + 2);
      chk("R5 short release ignored", sys_rst_n_o, 0);
      mr_n_i = 1'b1;
      tick(M + LEN - 1);
      chk("R5 low until filtered release plus LEN", sys_rst_n_o, 0);
      tick(1);
      chk("R5 released", sys_rst_n_o, 1);
   endtask

   task automatic t_priority();
      supply_fail_i = 1'b1;
      mr_n_i = 1'b0;
      tick(D + 1);
      chk("R8 supply beats manual", cause_o, 1);
      wdog_fault_i = 1'b1; tick(1); wdog_fault_i = 1'b0;
      chk("R8 supply beats watchdog", cause_o, 1);
      supply_fail_i = 1'b0;
      supply_ok_rise_i = 1'b1; tick(2); supply_ok_rise_i = 1'b0;
      chk("R8 manual reported after supply clears", cause_o, 2);
      chk("R4 still low with manual held", sys_rst_n_o, 0);
      mr_n_i = 1'b1;
      tick(M + LEN + 2);
      chk("R7 all clear releases", sys_rst_n_o, 1);
   endtask

   initial begin
      arst_n = 1'b0;
      supply_fail_i = 1'b0; supply_ok_rise_i = 1'b0;
      mr_n_i = 1'b1; wdog_fault_i = 1'b0;
      rst_len_i = CNT_W'(LEN);
      @(negedge clk);
      t_power_on();
      t_wdog();
      t_len_zero();
      t_reload();
      t_short_dip();
      t_supply();
      t_mr_short();
      t_mr();
      t_priority();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #200000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule